// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer of a simple CPU model with a byte-wide bus. At an instruction boundary it decides whether to take a maskable interrupt. If it takes one, it drives the whole entry sequence, one bus operation per clock:

- six byte pushes that save the flags, the code segment and the instruction pointer;
- two interrupt-acknowledge cycles, which return the type number n;
- four reads of the vector table, at byte address 4n in segment zero;
- a single load of the new context.

A separate return command pops the six saved bytes and restores the interrupted context.

The surrounding core presents its current flags word, CS, IP, SS and SP. It asserts `instrDone` in the cycle an instruction completes. While `busy` is high it stalls instruction fetch. When `ctxLoad` pulses, it takes the new flags, CS, IP and SP from the context outputs.

Read data for a read or acknowledge cycle is returned in the same cycle the operation is presented. It is captured at the clock edge that ends that cycle.

Top module: `isr_seq`

## Requirements
- R1: After reset, `busy` and `ctxLoad` are 0 and `busOp` is idle. The `busOp` encoding is 00 idle, 01 write, 10 read and 11 acknowledge.
- R2: An interrupt is taken only at a rising clock edge where `instrDone`, `intReq` and the interrupt-enable bit (bit 9 of `curFlags`) are all 1. If any one of them is 0, there is no bus activity and `busy` stays 0.
- R3: In cycles 1 to 6 after the accepting edge, the block drives writes. Each write goes to address `(curSs*16 + ((curSp-k) mod 2^16)) mod 2^20`, for k = 1 to 6. The data bytes are, in order: flags high, flags low, CS high, CS low, IP high, IP low.
- R4: Cycles 7 and 8 are acknowledge cycles. The type byte n is taken only from the read data of the second acknowledge cycle. The first acknowledge cycle's data is ignored.
- R5: Cycles 9 to 12 are reads at addresses 4n, 4n+1, 4n+2 and 4n+3, all in segment zero. The four bytes are IP low, IP high, CS low and CS high.
- R6: Cycle 13 of an entry has `ctxLoad` high for exactly one cycle. In that cycle:
  - `ctxIp` and `ctxCs` come from the vector bytes;
  - `ctxFlags` equals the entry flags with bits 9 (interrupt enable) and 8 (trap) cleared;
  - `ctxSp` equals the entry SP minus 6.
- R7: `busy` is high in every cycle from 1 to the load cycle, and low in the cycle after the load.
- R8: A return command taken in the idle state starts a pop sequence:
  - Cycles 1 to 6 read from `curSs*16 + curSp + k - 1`, for k = 1 to 6. The bytes are taken as IP low, IP high, CS low, CS high, flags low, flags high.
  - Cycle 7 pulses `ctxLoad`, with the popped IP, CS and flags and with SP plus 6.
- R9: `retCmd` is ignored while a sequence is running. If it is asserted at the same edge that takes an interrupt, the interrupt wins and the return is dropped.
- R10: Stack offsets wrap modulo 2^16, and stack addresses are truncated to 20 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intReq | input | 1 | Maskable interrupt request line |
| instrDone | input | 1 | Current instruction has finished executing |
| retCmd | input | 1 | Start the return (pop) sequence |
| curFlags | input | 16 | Current flags word (bit 9 interrupt enable, bit 8 trap) |
| curCs | input | 16 | Current code segment |
| curIp | input | 16 | Current instruction pointer |
| curSs | input | 16 | Current stack segment |
| curSp | input | 16 | Current stack pointer |
| busRdData | input | 8 | Read or acknowledge data, valid in the same cycle |
| busOp | output | 2 | Bus operation: 00 idle, 01 write, 10 read, 11 acknowledge |
| busAddr | output | 20 | Byte address of the operation |
| busWrData | output | 8 | Write data |
| busy | output | 1 | Sequence running; fetch must stall |
| ctxLoad | output | 1 | One-cycle strobe: load the context outputs |
| ctxFlags | output | 16 | New flags word |
| ctxCs | output | 16 | New code segment |
| ctxIp | output | 16 | New instruction pointer |
| ctxSp | output | 16 | New stack pointer |

## Verification
The bench builds the block with its defaults: a 20-bit address, a 4-bit segment shift, enable and trap at bits 9 and 8, and an 8-bit type number. These keep all 256 type numbers within reach, so every vector-table slot is swept, each followed by a return that must restore the original context. On the acknowledge cycles the first returns the complement of the type and the second the type itself, which exposes a capture on the wrong cycle. Small stack pointers and a top-of-memory stack segment make the 16-bit offset wrap and the 20-bit address truncation both visible.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int CTX_BYTES = 6;  // flags, CS, IP as bytes
  localparam int VEC_BYTES = 4;  // IP and CS from the table
  localparam int IDX_W     = $clog2(CTX_BYTES);

  localparam logic [1:0] OP_IDLE = 2'b00;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_ACK  = 2'b11;

  typedef struct packed {
    logic             capCtx;   // latch current context
    logic             clrMask;  // clear enable and trap bits
    logic             capType;  // latch type byte
    logic             pushWr;   // stack write, byte selected by byteIdx
    logic             popRd;    // stack read
    logic             vecRd;    // vector table read
    logic [IDX_W-1:0] byteIdx;
  } strobes_t;
endpackage

// File: rtl/isr_seq_ctrl.sv
module isr_seq_ctrl
  import isr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic       intReq,
  input  logic       ifFlag,
  input  logic       retCmd,
  output strobes_t   strb,
  output logic [1:0] busOp,
  output logic       busy,
  output logic       ctxLoad
);
  typedef enum logic [2:0] {
    S_IDLE, S_PUSH, S_ACK1, S_ACK2, S_VEC, S_POP, S_LOAD
  } state_e;

  state_e           state, nextState;
  logic [IDX_W-1:0] cnt, nextCnt;
  logic             takeInt, takeRet, lastPush, lastVec;

  assign takeInt  = (state == S_IDLE) && instrDone && intReq && ifFlag;
  assign takeRet  = (state == S_IDLE) && retCmd && !takeInt;
  assign lastPush = (cnt == IDX_W'(CTX_BYTES - 1));
  assign lastVec  = (cnt == IDX_W'(VEC_BYTES - 1));

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    case (state)
      S_IDLE: begin
        nextCnt = '0;
        if (takeInt)      nextState = S_PUSH;
        else if (takeRet) nextState = S_POP;
      end
      S_PUSH: begin
        if (lastPush) begin
          nextState = S_ACK1;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      S_ACK1: nextState = S_ACK2;
      S_ACK2: begin
        nextState = S_VEC;
        nextCnt   = '0;
      end
      S_VEC: begin
        if (lastVec) nextState = S_LOAD;
        else         nextCnt   = cnt + 1'b1;
      end
      S_POP: begin
        if (lastPush) nextState = S_LOAD;
        else          nextCnt   = cnt + 1'b1;
      end
      S_LOAD:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  always_comb begin
    strb         = '0;
    strb.byteIdx = cnt;
    busOp        = OP_IDLE;
    strb.capCtx  = takeInt || takeRet;
    case (state)
      S_PUSH: begin
        busOp       = OP_WR;
        strb.pushWr = 1'b1;
      end
      S_ACK1: begin
        busOp        = OP_ACK;
        strb.clrMask = 1'b1;
      end
      S_ACK2: begin
        busOp        = OP_ACK;
        strb.capType = 1'b1;
      end
      S_VEC: begin
        busOp      = OP_RD;
        strb.vecRd = 1'b1;
      end
      S_POP: begin
        busOp      = OP_RD;
        strb.popRd = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign ctxLoad = (state == S_LOAD);

  // R2: without a full entry condition or a return command, idle persists
  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !(instrDone && intReq && ifFlag) && !retCmd)
      |=> (state == S_IDLE));

  // R3: acknowledge phase follows only the push phase
  p_push_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACK1) |-> ($past(state) == S_PUSH));

  // R4: acknowledge cycles come in pairs
  p_ack_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busOp == OP_ACK && state == S_ACK1) |=> (busOp == OP_ACK));

  // R6, R7: one-cycle load, then idle
  p_load_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctxLoad |=> (!ctxLoad && !busy));

  // R9: a running entry never turns into a pop
  p_ret_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {S_PUSH, S_ACK1, S_ACK2, S_VEC}) |=> (state != S_POP));
endmodule

// File: rtl/isr_seq_dpath.sv
module isr_seq_dpath
  import isr_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int TYPE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [WORD_W-1:0] curFlags,
  input  logic [WORD_W-1:0] curCs,
  input  logic [WORD_W-1:0] curIp,
  input  logic [WORD_W-1:0] curSs,
  input  logic [WORD_W-1:0] curSp,
  input  logic [BYTE_W-1:0] busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BYTE_W-1:0] busWrData,
  output logic [WORD_W-1:0] ctxFlags,
  output logic [WORD_W-1:0] ctxCs,
  output logic [WORD_W-1:0] ctxIp,
  output logic [WORD_W-1:0] ctxSp
);
  localparam int VEC_SPAN = TYPE_W + 2;  // log2 of table size in bytes

  logic [WORD_W-1:0] flagsR, csR, ipR, ssR, spR;
  logic [TYPE_W-1:0] typeR;
  logic [WORD_W-1:0] spDown;
  logic [ADDR_W-1:0] segBase, stkAddr, vecAddr;
  logic [BYTE_W-1:0] pushByte;

  assign spDown  = spR - 1'b1;
  assign segBase = ADDR_W'({ssR, {SEG_SHIFT{1'b0}}});
  assign stkAddr = segBase + ADDR_W'(strb.pushWr ? spDown : spR);
  assign vecAddr = ADDR_W'({typeR, 2'b00}) + ADDR_W'(strb.byteIdx);

  always_comb begin
    case (strb.byteIdx)
      3'd0:    pushByte = flagsR[15:8];
      3'd1:    pushByte = flagsR[7:0];
      3'd2:    pushByte = csR[15:8];
      3'd3:    pushByte = csR[7:0];
      3'd4:    pushByte = ipR[15:8];
      default: pushByte = ipR[7:0];
    endcase
  end

  always_comb begin
    if (strb.vecRd)                     busAddr = vecAddr;
    else if (strb.pushWr || strb.popRd) busAddr = stkAddr;
    else                                busAddr = '0;
  end

  assign busWrData = strb.pushWr ? pushByte : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsR <= '0;
      csR    <= '0;
      ipR    <= '0;
      ssR    <= '0;
      spR    <= '0;
      typeR  <= '0;
    end else begin
      if (strb.capCtx) begin
        flagsR <= curFlags;
        csR    <= curCs;
        ipR    <= curIp;
        ssR    <= curSs;
        spR    <= curSp;
      end
      if (strb.pushWr) spR <= spDown;
      if (strb.clrMask) begin
        flagsR[IF_BIT] <= 1'b0;
        flagsR[TF_BIT] <= 1'b0;
      end
      if (strb.capType) typeR <= busRdData;
      if (strb.vecRd) begin
        case (strb.byteIdx)
          3'd0:    ipR[7:0]  <= busRdData;
          3'd1:    ipR[15:8] <= busRdData;
          3'd2:    csR[7:0]  <= busRdData;
          default: csR[15:8] <= busRdData;
        endcase
      end
      if (strb.popRd) begin
        spR <= spR + 1'b1;
        case (strb.byteIdx)
          3'd0:    ipR[7:0]     <= busRdData;
          3'd1:    ipR[15:8]    <= busRdData;
          3'd2:    csR[7:0]     <= busRdData;
          3'd3:    csR[15:8]    <= busRdData;
          3'd4:    flagsR[7:0]  <= busRdData;
          default: flagsR[15:8] <= busRdData;
        endcase
      end
    end
  end

  assign ctxFlags = flagsR;
  assign ctxCs    = csR;
  assign ctxIp    = ipR;
  assign ctxSp    = spR;

  // R5: vector reads stay inside the table at the bottom of segment zero
  p_vec_seg0_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.vecRd |-> ((busAddr >> VEC_SPAN) == '0));

  // R3: a push never drives write data while a read is selected
  p_push_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushWr |-> (!strb.popRd && !strb.vecRd));
endmodule

// File: rtl/isr_seq.sv
module isr_seq
  import isr_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int TYPE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intReq,
  input  logic              instrDone,
  input  logic              retCmd,
  input  logic [15:0]       curFlags,
  input  logic [15:0]       curCs,
  input  logic [15:0]       curIp,
  input  logic [15:0]       curSs,
  input  logic [15:0]       curSp,
  input  logic [7:0]        busRdData,
  output logic [1:0]        busOp,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  output logic              busy,
  output logic              ctxLoad,
  output logic [15:0]       ctxFlags,
  output logic [15:0]       ctxCs,
  output logic [15:0]       ctxIp,
  output logic [15:0]       ctxSp
);
  strobes_t strb;

  isr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrDone (instrDone),
    .intReq    (intReq),
    .ifFlag    (curFlags[IF_BIT]),
    .retCmd    (retCmd),
    .strb      (strb),
    .busOp     (busOp),
    .busy      (busy),
    .ctxLoad   (ctxLoad)
  );

  isr_seq_dpath #(
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .IF_BIT    (IF_BIT),
    .TF_BIT    (TF_BIT),
    .TYPE_W    (TYPE_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .curFlags  (curFlags),
    .curCs     (curCs),
    .curIp     (curIp),
    .curSs     (curSs),
    .curSp     (curSp),
    .busRdData (busRdData),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .ctxFlags  (ctxFlags),
    .ctxCs     (ctxCs),
    .ctxIp     (ctxIp),
    .ctxSp     (ctxSp)
  );
endmodule

// File: tb/tb_isr_seq.sv
`timescale 1ns/1ps
module tb_isr_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intReq = 1'b0, instrDone = 1'b0, retCmd = 1'b0;
  logic [15:0] curFlags = '0, curCs = '0, curIp = '0, curSs = '0, curSp = '0;
  logic [7:0]  busRdData;
  logic [1:0]  busOp;
  logic [19:0] busAddr;
  logic [7:0]  busWrData;
  logic        busy, ctxLoad;
  logic [15:0] ctxFlags, ctxCs, ctxIp, ctxSp;

  int nChecks = 0;
  int nErrs = 0;
  bit finished = 0;

  logic [7:0] stk [0:255];
  logic       popMode = 1'b0;
  logic       ackToggle;
  logic [7:0] ackVal = '0;

  always #2.5 clk = ~clk;

  isr_seq dut (.*);

  function automatic logic [7:0] vecByte(input int a);
    vecByte = 8'(((a * 37) + (a >> 3) + 11) & 255);
  endfunction

  always_comb begin
    case (busOp)
      2'b11:   busRdData = ackToggle ? ackVal : ~ackVal;
      2'b10:   busRdData = popMode ? stk[busAddr[7:0]] : vecByte(int'(busAddr));
      default: busRdData = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    if (!rstN) ackToggle <= 1'b0;
    else if (busOp == 2'b11) ackToggle <= ~ackToggle;
    if (busOp == 2'b01) stk[busAddr[7:0]] <= busWrData;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkQuiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(req, "busy stays low", 32'(busy), 0);
      chk(req, "bus stays idle", 32'(busOp), 0);
    end
  endtask

  task automatic runEntry(input logic [7:0] n, input logic [15:0] fl,
                          input logic [15:0] cs, input logic [15:0] ip,
                          input logic [15:0] ss, input logic [15:0] sp,
                          input bit retWith, input bit retMid);
    logic [7:0]  expData [6];
    logic [15:0] expIp, expCs;
    expData[0] = fl[15:8]; expData[1] = fl[7:0];
    expData[2] = cs[15:8]; expData[3] = cs[7:0];
    expData[4] = ip[15:8]; expData[5] = ip[7:0];
    expIp = {vecByte(4*n + 1), vecByte(4*n)};
    expCs = {vecByte(4*n + 3), vecByte(4*n + 2)};
    @(negedge clk);
    popMode = 1'b0; ackVal = n;
    curFlags = fl; curCs = cs; curIp = ip; curSs = ss; curSp = sp;
    intReq = 1'b1; instrDone = 1'b1; retCmd = retWith;
    @(negedge clk);
    intReq = 1'b0; instrDone = 1'b0; retCmd = 1'b0;
    for (int k = 1; k <= 13; k++) begin
      if (retMid && k == 3) retCmd = 1'b1;
      if (retMid && k == 4) retCmd = 1'b0;
      chk("R7", "busy during entry", 32'(busy), 1);
      if (k <= 6) begin
        chk("R3", "push op", 32'(busOp), 1);
        chk("R10", "push addr",
            32'(busAddr), 32'((({4'h0, ss} << 4) + 20'(16'(sp - 16'(k)))) & 20'hFFFFF));
        chk("R3", "push data", 32'(busWrData), 32'(expData[k-1]));
      end else if (k <= 8) begin
        chk("R4", "ack op", 32'(busOp), 3);
      end else if (k <= 12) begin
        chk("R5", "vector read op", 32'(busOp), 2);
        chk("R5", "vector addr", 32'(busAddr), 32'(4*n + k - 9));
      end else begin
        chk("R6", "load strobe", 32'(ctxLoad), 1);
        chk("R6", "load ip", 32'(ctxIp), 32'(expIp));
        chk("R4", "load cs from second-ack type", 32'(ctxCs), 32'(expCs));
        chk("R6", "flags masked", 32'(ctxFlags), 32'(fl & 16'hFCFF));
        chk("R6", "sp after pushes", 32'(ctxSp), 32'(16'(sp - 16'd6)));
      end
      if (k < 13) chk("R6", "no early load", 32'(ctxLoad), 0);
      @(negedge clk);
    end
    chk("R7", "busy drops after load", 32'(busy), 0);
    chk("R6", "load is one cycle", 32'(ctxLoad), 0);
    if (retWith || retMid) checkQuiet("R9", 2);
  endtask

  task automatic runReturn(input logic [15:0] ss, input logic [15:0] sp,
                           input logic [15:0] fl, input logic [15:0] cs,
                           input logic [15:0] ip);
    @(negedge clk);
    popMode = 1'b1; curSs = ss; curSp = sp; retCmd = 1'b1;
    @(negedge clk);
    retCmd = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      chk("R8", "busy during return", 32'(busy), 1);
      if (k <= 6) begin
        chk("R8", "pop op", 32'(busOp), 2);
        chk("R10", "pop addr",
            32'(busAddr), 32'((({4'h0, ss} << 4) + 20'(16'(sp + 16'(k - 1)))) & 20'hFFFFF));
      end else begin
        chk("R8", "return load", 32'(ctxLoad), 1);
        chk("R8", "restored ip", 32'(ctxIp), 32'(ip));
        chk("R8", "restored cs", 32'(ctxCs), 32'(cs));
        chk("R8", "restored flags", 32'(ctxFlags), 32'(fl));
        chk("R8", "restored sp", 32'(ctxSp), 32'(16'(sp + 16'd6)));
      end
      @(negedge clk);
    end
    chk("R8", "idle after return", 32'(busy), 0);
    popMode = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      nErrs++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", 32'(busy), 0);
    chk("R1", "reset op", 32'(busOp), 0);
    chk("R1", "reset load", 32'(ctxLoad), 0);
    rstN = 1'b1;

    // R2: each missing condition blocks entry
    @(negedge clk);
    curFlags = 16'h0000; intReq = 1'b1; instrDone = 1'b1;
    checkQuiet("R2", 3);
    curFlags = 16'h0200; instrDone = 1'b0;
    checkQuiet("R2", 3);
    intReq = 1'b0; instrDone = 1'b1;
    checkQuiet("R2", 3);
    instrDone = 1'b0;

    // R5, R6, R8: sweep of every type number with round-trip return
    for (int n = 0; n < 256; n++) begin
      logic [15:0] fl, cs, ip, sp;
      fl = 16'h0200 | (16'(n * 97) & 16'hFCFF) | ((n & 1) != 0 ? 16'h0100 : 16'h0000);
      cs = 16'(n * 257) ^ 16'h1234;
      ip = ~cs + 16'(n);
      sp = 16'h0080 + 16'(n);
      runEntry(8'(n), fl, cs, ip, 16'h1000, sp, 1'b0, 1'b0);
      runReturn(16'h1000, 16'(sp - 16'd6), fl, cs, ip);
    end

    // R10: offset wrap and 20-bit truncation
    runEntry(8'h21, 16'h0A55, 16'hBEEF, 16'h1357, 16'h1000, 16'h0003, 1'b0, 1'b0);
    runReturn(16'h1000, 16'hFFFD, 16'h0A55, 16'hBEEF, 16'h1357);
    runEntry(8'hC3, 16'h0312, 16'h4242, 16'h8001, 16'hFFFF, 16'h0030, 1'b0, 1'b0);
    runReturn(16'hFFFF, 16'h002A, 16'h0312, 16'h4242, 16'h8001);

    // R9: return ignored when simultaneous with entry and while running
    runEntry(8'h7F, 16'h0200, 16'h0001, 16'h0002, 16'h1000, 16'h0100, 1'b1, 1'b0);
    runEntry(8'h80, 16'h0300, 16'h0003, 16'h0004, 16'h1000, 16'h0100, 1'b0, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
    $finish;
  end
endmodule